// File: doc/BRIEF.md
# Segmented Multichannel Sample Buffer

This block holds 64 complex sample words (16-bit I, 16-bit Q) in one shared memory. The memory can be divided into one, two or four equal channel segments. Each segment is a FIFO for arriving samples, and it is also the tap delay line for a downstream interpolation filter. That filter reads any past sample of a channel by giving the channel number and a tap offset.

Samples come from one of two sources. The first is a deserialized serial path, whose write strobe comes from an external serial controller. The second is a register-write path. Every sample is complex; there is no real-only input. For each channel, a request output says whether the channel can take another complex sample. The filter frees a slot with a per-channel advance strobe, so the request pattern need not be periodic.

The control state machine has two states:
- `ST_CLEAR`: requests are held low, writes are ignored, and the segment pointers, fill counts and overflow flags are reset. The segmentation is latched in this state.
- `ST_RUN`: normal operation.

The machine moves `ST_CLEAR -> ST_RUN` unconditionally after one cycle. It moves `ST_RUN -> ST_CLEAR` when the channel-count input differs from the latched segmentation. Reset enters `ST_CLEAR`.

Top module: `sbuf_seg_top`

## Requirements
- R1: `cfg_chans` selects the segmentation: 0 gives one 64-word segment (channel 0); 1 gives two 32-word segments (channels 0-1); 2 or 3 gives four 16-word segments (channels 0-3).
- R2: While `rst_n` is low, `req` and `ovf` are all zero. In the cycle after the first clock edge with `rst_n` high, `req` is high for every active channel.
- R3: `req[c]` is high exactly when channel c is active, the machine is in `ST_RUN`, and the channel holds fewer unconsumed samples than its segment length. Inactive channels never request.
- R4: A `ser_stb` pulse writes `{ser_i, ser_q}` to channel `ser_chan`. A `reg_wr` pulse writes `{reg_i, reg_q}` to channel `reg_chan`. When both pulse in the same cycle, only the serial sample is stored and the register sample is dropped.
- R5: `rd_i`/`rd_q` show, one clock after `rd_chan`/`rd_tap` are applied, the sample that was written `rd_tap+1` writes ago on that channel. Tap 0 is the newest sample. The tap is taken modulo the segment length.
- R6: An `adv[c]` pulse frees one slot of active channel c. It is ignored when the channel is empty. A write and an advance on the same channel in the same cycle leave the fill count unchanged.
- R7: A write to a full active channel is dropped and sets the sticky bit `ovf[c]`. The stored samples stay unchanged, and no other channel's flag changes.
- R8: A write to an inactive channel is ignored: it sets no flag and changes no request.
- R9: When `cfg_chans` changes the segmentation during `ST_RUN`, the next cycle shows `req` and `ovf` all zero. One cycle later every active channel of the new layout requests again, with an empty segment.
- R10: Write pointers wrap inside their own segment. Tap reads across the wrap return the right history, and the channels never overwrite one another.
- R11: The control machine has exactly the states `ST_CLEAR` and `ST_RUN`, with the transitions named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chans | input | 2 | Segmentation select: 0 = one, 1 = two, 2/3 = four segments |
| ser_stb | input | 1 | Serial-path sample ready strobe |
| ser_chan | input | 2 | Serial-path target channel |
| ser_i | input | 16 | Serial-path I word |
| ser_q | input | 16 | Serial-path Q word |
| reg_wr | input | 1 | Register-path write strobe |
| reg_chan | input | 2 | Register-path target channel |
| reg_i | input | 16 | Register-path I word |
| reg_q | input | 16 | Register-path Q word |
| adv | input | 4 | Per-channel slot release from the filter |
| rd_chan | input | 2 | Tap read channel |
| rd_tap | input | 6 | Tap read offset (0 = newest) |
| req | output | 4 | Per-channel ready-for-sample request |
| ovf | output | 4 | Per-channel sticky overflow flag |
| rd_i | output | 16 | Tap read I word, one cycle latency |
| rd_q | output | 16 | Tap read Q word, one cycle latency |

## Verification
In every segmentation, the bench fills every active channel exactly to its length and reads back every tap. A wrong segment base or pointer mask would show up as samples from another channel or as a shifted history. Before filling, it advances an empty channel; a design that underflows the count would then drop its request one sample early or late. It pushes past full to expose a design that overwrites the delay line instead of flagging overflow. Finally, it mixes advance-with-write, wrap-around and modulo tap offsets, pulses both sources at once, writes to an inactive channel, and changes the layout while flags are set, so that pointer drift, a lost source priority, or stale requests and flags across a reconfiguration are each caught.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        SEG_ONE  = 2'd0,
        SEG_TWO  = 2'd1,
        SEG_FOUR = 2'd2
    } seg_mode_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } buf_state_e;

    function automatic seg_mode_e norm_mode(input logic [1:0] raw);
        unique case (raw)
            2'd0:    return SEG_ONE;
            2'd1:    return SEG_TWO;
            default: return SEG_FOUR;
        endcase
    endfunction

endpackage

// File: rtl/sbuf_chan_ctrl.sv
module sbuf_chan_ctrl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW:0]   seg_len,
    input  logic [AW-1:0] ptr_mask,
    input  logic          hit,
    input  logic          adv,
    output logic [AW-1:0] wptr,
    output logic          full,
    output logic          we,
    output logic          ovf
);
    logic [AW:0] cnt_q;
    logic        do_adv;

    assign full   = (cnt_q == seg_len);
    assign we     = hit && !full;
    assign do_adv = adv && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wptr  <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            wptr  <= '0;
            ovf   <= 1'b0;
        end else begin
            if (we) begin
                wptr <= (wptr + 1'b1) & ptr_mask;
            end
            if (we && !do_adv) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (!we && do_adv) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (hit && full) begin
                ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbuf_addr.sv
module sbuf_addr
    import sbuf_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NCH = 4
) (
    input  seg_mode_e                   mode,
    input  logic [1:0]                  wchan,
    input  logic [1:0]                  rchan,
    input  logic [AW-1:0]               rtap,
    input  logic [NCH-1:0][AW-1:0]      wptr_v,
    output logic [AW-1:0]               ptr_mask,
    output logic [AW-1:0]               waddr,
    output logic [AW-1:0]               raddr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    int          shift;
    logic [AW-1:0] wbase;
    logic [AW-1:0] rbase;
    logic [AW-1:0] roff;

    always_comb begin
        shift    = AW - int'(mode);
        ptr_mask = (ONE << shift) - ONE;
        wbase    = AW'(wchan) << shift;
        rbase    = AW'(rchan) << shift;
        roff     = (wptr_v[rchan] - ONE - rtap) & ptr_mask;
        waddr    = wbase | (wptr_v[wchan] & ptr_mask);
        raddr    = rbase | roff;
    end
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sbuf_seg_top.sv
module sbuf_seg_top
    import sbuf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORDS  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_chans,
    input  logic                       ser_stb,
    input  logic [1:0]                 ser_chan,
    input  logic [DATA_W-1:0]          ser_i,
    input  logic [DATA_W-1:0]          ser_q,
    input  logic                       reg_wr,
    input  logic [1:0]                 reg_chan,
    input  logic [DATA_W-1:0]          reg_i,
    input  logic [DATA_W-1:0]          reg_q,
    input  logic [3:0]                 adv,
    input  logic [1:0]                 rd_chan,
    input  logic [$clog2(WORDS)-1:0]   rd_tap,
    output logic [3:0]                 req,
    output logic [3:0]                 ovf,
    output logic [DATA_W-1:0]          rd_i,
    output logic [DATA_W-1:0]          rd_q
);
    localparam int AW  = $clog2(WORDS);
    localparam int NCH = 4;
    localparam int SW  = 2 * DATA_W;

    buf_state_e st_q, st_n;
    seg_mode_e  mode_q, mode_n;

    logic                  in_run, chg, clr, run_ok;
    logic [AW:0]           seg_len;
    logic [AW-1:0]         ptr_mask;
    logic [NCH-1:0]        active;
    logic [NCH-1:0]        hit, adv_ok, we, full;
    logic [NCH-1:0][AW-1:0] wptr_v;
    logic                  wsel_v;
    logic [1:0]            wsel_chan;
    logic [SW-1:0]         wsel_data;
    logic [AW-1:0]         waddr, raddr;
    logic [SW-1:0]         rdata;

    assign mode_n = norm_mode(cfg_chans);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_CLEAR;
            mode_q <= SEG_ONE;
        end else begin
            st_q <= st_n;
            if (st_q == ST_CLEAR || chg) begin
                mode_q <= mode_n;
            end
        end
    end

    // Next state and outputs process
    always_comb begin
        in_run = (st_q == ST_RUN);
        chg    = in_run && (mode_n != mode_q);
        st_n   = st_q;
        unique case (st_q)
            ST_CLEAR: st_n = ST_RUN;
            ST_RUN:   st_n = chg ? ST_CLEAR : ST_RUN;
        endcase
        clr     = !in_run || chg;
        run_ok  = in_run && !chg;
        seg_len = (AW + 1)'(WORDS) >> mode_q;

        if (ser_stb) begin
            wsel_v    = 1'b1;
            wsel_chan = ser_chan;
            wsel_data = {ser_i, ser_q};
        end else begin
            wsel_v    = reg_wr;
            wsel_chan = reg_chan;
            wsel_data = {reg_i, reg_q};
        end

        for (int c = 0; c < NCH; c++) begin
            active[c] = (c < (1 << int'(mode_q)));
            hit[c]    = run_ok && wsel_v && active[c] && (wsel_chan == 2'(c));
            adv_ok[c] = run_ok && active[c] && adv[c];
            req[c]    = in_run && active[c] && !full[c];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        sbuf_chan_ctrl #(.AW(AW)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .seg_len  (seg_len),
            .ptr_mask (ptr_mask),
            .hit      (hit[g]),
            .adv      (adv_ok[g]),
            .wptr     (wptr_v[g]),
            .full     (full[g]),
            .we       (we[g]),
            .ovf      (ovf[g])
        );
    end

    sbuf_addr #(.AW(AW), .NCH(NCH)) u_addr (
        .mode     (mode_q),
        .wchan    (wsel_chan),
        .rchan    (rd_chan),
        .rtap     (rd_tap),
        .wptr_v   (wptr_v),
        .ptr_mask (ptr_mask),
        .waddr    (waddr),
        .raddr    (raddr)
    );

    sbuf_store #(.AW(AW), .DW(SW)) u_store (
        .clk   (clk),
        .we    (|we),
        .waddr (waddr),
        .wdata (wsel_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign rd_i = rdata[SW-1:DATA_W];
    assign rd_q = rdata[DATA_W-1:0];

endmodule

// File: rtl/sbuf_seg_chk.sv
module sbuf_seg_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_run,
    input logic           chg,
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] ovf,
    input logic [NCH-1:0] full,
    input logic [NCH-1:0] active,
    input logic [NCH-1:0] we
);
    // R3: no request from a channel outside the current layout
    a_r3_no_req_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (req & ~active) == '0);

    // R9: a layout change is followed by a cycle with nothing requested or flagged
    a_r9_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (req == '0 && ovf == '0));

    // R4: at most one segment accepts a sample per cycle
    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    // R7: flags never drop while running without a layout change
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !chg) |=> ((ovf & $past(ovf)) == $past(ovf)));

    // R11: the clear state lasts a single cycle
    a_r11_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |=> in_run);

    for (genvar g = 0; g < NCH; g++) begin : g_bit
        // R7: a flag rises only after a write met a full segment
        a_r7_ovf_from_full: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf[g]) |-> $past(full[g]));
    end
endmodule

bind sbuf_seg_top sbuf_seg_chk #(.NCH(4)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_run (in_run),
    .chg    (chg),
    .req    (req),
    .ovf    (ovf),
    .full   (full),
    .active (active),
    .we     (we)
);

// File: tb/test_sbuf_seg_top.sv
module test_sbuf_seg_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_chans;
    logic        ser_stb, reg_wr;
    logic [1:0]  ser_chan, reg_chan, rd_chan;
    logic [15:0] ser_i, ser_q, reg_i, reg_q;
    logic [3:0]  adv;
    logic [5:0]  rd_tap;
    logic [3:0]  req, ovf;
    logic [15:0] rd_i, rd_q;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sbuf_seg_top i_sbuf_seg_top (
        .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans),
        .ser_stb(ser_stb), .ser_chan(ser_chan), .ser_i(ser_i), .ser_q(ser_q),
        .reg_wr(reg_wr), .reg_chan(reg_chan), .reg_i(reg_i), .reg_q(reg_q),
        .adv(adv), .rd_chan(rd_chan), .rd_tap(rd_tap),
        .req(req), .ovf(ovf), .rd_i(rd_i), .rd_q(rd_q)
    );

    function automatic logic [15:0] mk(input int m, input int c, input int n);
        return {4'(m), 4'(c), 8'(n)};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input bit use_reg, input int c, input logic [15:0] d, input bit with_adv);
        if (use_reg) begin
            reg_wr = 1'b1; reg_chan = 2'(c); reg_i = d; reg_q = d ^ 16'h5A5A;
        end else begin
            ser_stb = 1'b1; ser_chan = 2'(c); ser_i = d; ser_q = d ^ 16'h5A5A;
        end
        if (with_adv) adv[c] = 1'b1;
        tick();
        reg_wr = 1'b0; ser_stb = 1'b0; adv = '0;
    endtask

    task automatic rd_chk(input int c, input int t, input logic [15:0] e, input string tag);
        rd_chan = 2'(c); rd_tap = 6'(t);
        tick();
        chk(rd_i == e && rd_q == (e ^ 16'h5A5A), tag, {rd_i, rd_q}, {e, e ^ 16'h5A5A});
    endtask

    task automatic run_mode(input int m);
        int len  = 64 >> m;
        int nch  = 1 << m;
        logic [3:0] mask = 4'((1 << nch) - 1);
        cfg_chans = 2'(m);
        tick();
        chk(req == 4'h0, "R9 req low in clear cycle", 32'(req), 32'h0);
        chk(ovf == 4'h0, "R9 ovf cleared", 32'(ovf), 32'h0);
        tick();
        chk(req == mask, "R1 R3 R9 active mask requests", 32'(req), 32'(mask));
        for (int c = 0; c < nch; c++) begin
            adv[c] = 1'b1; tick(); adv = '0;          // R6 advance on empty ignored
            for (int n = 0; n < len; n++) begin
                put(n[0], c, mk(m, c, n), 1'b0);
                if (n == len - 2) chk(req[c] == 1'b1, "R6 room before last slot", 32'(req), 32'(mask));
            end
            chk(req[c] == 1'b0, "R3 full channel stops requesting", 32'(req[c]), 32'h0);
            put(1'b0, c, mk(m, c, 250), 1'b0);
            chk(ovf == 4'((1 << (c + 1)) - 1), "R7 sticky overflow per channel", 32'(ovf), 32'((1 << (c + 1)) - 1));
        end
        if (m < 2) begin
            put(1'b1, 3, 16'hDEAD, 1'b0);
            chk(ovf[3] == 1'b0 && req == 4'h0, "R8 inactive write ignored", {28'h0, ovf[3], req[2:0]}, 32'h0);
        end
        for (int c = 0; c < nch; c++)
            for (int t = 0; t < len; t++)
                rd_chk(c, t, mk(m, c, len - 1 - t), "R5 R7 R10 tap history");
        for (int k = 0; k < 5; k++) begin
            adv[0] = 1'b1; tick(); adv = '0;
        end
        chk(req[0] == 1'b1, "R6 advance frees slots", 32'(req[0]), 32'h1);
        for (int k = 0; k < 5; k++) put(1'b0, 0, mk(m, 0, len + k), 1'b1);
        chk(req[0] == 1'b1, "R6 write with advance keeps count", 32'(req[0]), 32'h1);
        for (int k = 5; k < 10; k++) put(1'b1, 0, mk(m, 0, len + k), 1'b0);
        chk(req[0] == 1'b0, "R6 R10 refill to full after wrap", 32'(req[0]), 32'h0);
        for (int t = 0; t < 12; t++)
            rd_chk(0, t, mk(m, 0, len + 9 - t), "R10 wrapped history");
        if (len < 64) begin
            rd_chk(0, len, mk(m, 0, len + 9), "R5 tap modulo length");
            rd_chk(0, len + 3, mk(m, 0, len + 6), "R5 tap modulo length");
        end
        if (nch > 1) rd_chk(1, 0, mk(m, 1, len - 1), "R10 neighbour untouched by wrap");
        adv[0] = 1'b1; tick(); adv = '0;
        ser_stb = 1'b1; ser_chan = 2'd0; ser_i = mk(m, 0, 200); ser_q = mk(m, 0, 200) ^ 16'h5A5A;
        reg_wr  = 1'b1; reg_chan = 2'd0; reg_i = mk(m, 0, 201); reg_q = mk(m, 0, 201) ^ 16'h5A5A;
        tick();
        ser_stb = 1'b0; reg_wr = 1'b0;
        chk(req[0] == 1'b0, "R4 one sample taken", 32'(req[0]), 32'h0);
        rd_chk(0, 0, mk(m, 0, 200), "R4 serial wins");
        rd_chk(0, 1, mk(m, 0, len + 9), "R4 register sample dropped");
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_chans = 2'd0; ser_stb = 1'b0; reg_wr = 1'b0;
        ser_chan = '0; reg_chan = '0; ser_i = '0; ser_q = '0; reg_i = '0; reg_q = '0;
        adv = '0; rd_chan = '0; rd_tap = '0;
        repeat (3) tick();
        chk(req == 4'h0 && ovf == 4'h0, "R2 reset state", {24'h0, req, ovf}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk(req == 4'b0001, "R2 R11 request after reset", 32'(req), 32'h1);
        run_mode(2);
        run_mode(1);
        run_mode(0);
        cfg_chans = 2'd3;
        tick();
        chk(req == 4'h0, "R9 req low after change", 32'(req), 32'h0);
        tick();
        cfg_chans = 2'd2;
        tick();
        chk(req == 4'hF, "R1 codes 2 and 3 same layout", 32'(req), 32'hF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule